// File: doc/BRIEF.md
# Protected Multi-Block Flash Write Manager

This block turns a byte-range write request (start offset and length) into a sequence of erase and program operations for a flash engine that works on 64 KiB blocks. It holds two protection flags. One is a general write enable. The other separately unlocks the lowest 64 KiB, where boot code lives. It refuses requests that either flag forbids, checks the range against the selected device size, and clips overlong requests at the end of the device.

For each 64 KiB block the request touches, the manager first asks the engine to erase that block. It then asks the engine to program the bytes that fall inside the block. Erase failures and empty program results are retried within fixed budgets. When the request finishes, the manager pulses `done` and presents the number of bytes committed before any abort, together with a status code that names the outcome. The engine is outside this block. It answers each operation with `op_done` plus a pass flag (erase) or a byte count (program).

Top module: `flash_wr_mgr`

## Requirements
- R1: Control commands on `cmd_code`, taken when `cmd_valid` is high: 0 clears both enables, 1 sets the general enable, 2 sets the low-region enable, 3 is unknown. An unknown command clears both enables and raises `cmd_err` for the cycle after it.
- R2: A request is rejected with status 1 and zero bytes when the general enable is clear, or when the offset is below 65536 and the low-region enable is clear. No engine operation is issued.
- R3: The device size is 1 MiB when `size_sel` is 0 and 4 MiB when it is 1. An offset at or above the size gives status 2 and zero bytes if the length is nonzero, and status 0 with zero bytes if the length is zero. A zero-length request inside the device also completes at once with status 0 and zero bytes.
- R4: A length that runs past the end of the device is clipped, so a clean run writes exactly size minus offset bytes.
- R5: Each erase operation addresses a 64 KiB-aligned block address. The number of blocks processed is ((offset+len)>>16) − (offset>>16) + 1, less one when offset+len is a multiple of 65536.
- R6: Every program operation asks for a nonzero length that is no more than the bytes left in the request and that does not cross the next 64 KiB boundary.
- R7: The erase attempt counter is reset at the start of each block. When a failed erase brings that counter to 10, the write aborts with status 3.
- R8: A program result of zero bytes causes the block to be erased and programmed again. The tenth zero result for one block aborts the write with status 4.
- R9: After each successful program, the offset and the byte total both advance by the reported count. A run that completes every block ends with status 0. `done` is a single-cycle pulse, and `written` holds the bytes completed before any abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Control command strobe |
| cmd_code | input | 2 | Control command code |
| cmd_err | output | 1 | Unknown command seen (one cycle) |
| size_sel | input | 1 | Device size: 0 = 1 MiB, 1 = 4 MiB |
| req_valid | input | 1 | Write request strobe (taken when idle) |
| req_offset | input | AW | Request start offset |
| req_len | input | AW | Request length in bytes |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request finished (one cycle) |
| status | output | 3 | 0 ok, 1 protected, 2 range, 3 erase fail, 4 program fail |
| written | output | AW+1 | Bytes completed |
| op_start | output | 1 | Engine operation strobe |
| op_erase | output | 1 | 1 = erase, 0 = program |
| op_addr | output | AW | Block address (erase) or byte offset (program) |
| op_len | output | AW+1 | Program length |
| op_done | input | 1 | Engine operation finished |
| op_pass | input | 1 | Erase succeeded |
| op_bytes | input | BLK_SH+1 | Bytes the program step reports as written |

## Verification
Directed requests hit the corners. These include offsets just below and at 64 KiB with the low enable on and off, offsets at and past each device size with zero and nonzero lengths, and ends that land exactly on a block boundary or one byte past it, which separates the two block-count outcomes. Fault scripts make the first few erases or programs fail. Some stay under the retry budget and some reach it, so recovery and abort can be told apart, and each abort status is checked together with the partial byte count. Random requests over both sizes and all protection states are compared with a bench model for status, byte count and number of completed blocks.

// File: rtl/flash_wr_mgr.sv
module flash_wr_mgr #(
  parameter int AW     = 24,
  parameter int BLK_SH = 16,
  parameter int TRIES  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_code,
  output logic              cmd_err,
  input  logic              size_sel,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_offset,
  input  logic [AW-1:0]     req_len,
  output logic              busy,
  output logic              done,
  output logic [2:0]        status,
  output logic [AW:0]       written,
  output logic              op_start,
  output logic              op_erase,
  output logic [AW-1:0]     op_addr,
  output logic [AW:0]       op_len,
  input  logic              op_done,
  input  logic              op_pass,
  input  logic [BLK_SH:0]   op_bytes
);
  localparam int W       = AW + 1;
  localparam int CNT_W   = W - BLK_SH;
  localparam int TRY_W   = $clog2(TRIES + 1);
  localparam logic [W-1:0] BLK_BYTES = W'(1) << BLK_SH;
  localparam logic [W-1:0] SZ_SMALL  = W'(1) << 20;
  localparam logic [W-1:0] SZ_BIG    = W'(1) << 22;
  localparam logic [2:0] ST_OK = 3'd0, ST_PROT = 3'd1, ST_RANGE = 3'd2,
                         ST_EFAIL = 3'd3, ST_PFAIL = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_ERASE, S_EWAIT, S_PROG, S_PWAIT} state_t;
  state_t state;

  logic en_all, en_low;
  logic [AW-1:0]    cur_ofs;
  logic [W-1:0]     remain;
  logic [CNT_W-1:0] blocks;
  logic [TRY_W-1:0] ecnt, pcnt;

  logic [W-1:0] dev_size, ofs_w, len_w, room, clip_len, req_end, blk_room, prog_len;
  logic [W-1:0] blk_cnt_w;
  logic         prot_hit, out_range;

  assign dev_size  = size_sel ? SZ_BIG : SZ_SMALL;
  assign ofs_w     = {1'b0, req_offset};
  assign len_w     = {1'b0, req_len};
  assign prot_hit  = !en_all || ((ofs_w < BLK_BYTES) && !en_low);
  assign out_range = ofs_w >= dev_size;
  assign room      = dev_size - ofs_w;
  assign clip_len  = (len_w > room) ? room : len_w;
  assign req_end   = ofs_w + clip_len;
  assign blk_cnt_w = (req_end >> BLK_SH) - (ofs_w >> BLK_SH) + W'(1)
                     - ((req_end[BLK_SH-1:0] == '0) ? W'(1) : W'(0));

  assign blk_room  = BLK_BYTES - W'(cur_ofs[BLK_SH-1:0]);
  assign prog_len  = (remain < blk_room) ? remain : blk_room;

  assign busy     = state != S_IDLE;
  assign op_start = (state == S_ERASE) || (state == S_PROG);
  assign op_erase = state == S_ERASE;
  assign op_addr  = (state == S_ERASE) ? {cur_ofs[AW-1:BLK_SH], {BLK_SH{1'b0}}} : cur_ofs;
  assign op_len   = (state == S_PROG) ? prog_len : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_all  <= 1'b0;
      en_low  <= 1'b0;
      cmd_err <= 1'b0;
    end else begin
      cmd_err <= 1'b0;
      if (cmd_valid) begin
        case (cmd_code)
          2'd0: begin en_all <= 1'b0; en_low <= 1'b0; end
          2'd1: en_all <= 1'b1;
          2'd2: en_low <= 1'b1;
          default: begin en_all <= 1'b0; en_low <= 1'b0; cmd_err <= 1'b1; end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      done    <= 1'b0;
      status  <= ST_OK;
      written <= '0;
      cur_ofs <= '0;
      remain  <= '0;
      blocks  <= '0;
      ecnt    <= '0;
      pcnt    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          written <= '0;
          if (prot_hit) begin
            done <= 1'b1; status <= ST_PROT;
          end else if (out_range) begin
            done <= 1'b1; status <= (req_len == '0) ? ST_OK : ST_RANGE;
          end else if (clip_len == '0) begin
            done <= 1'b1; status <= ST_OK;
          end else begin
            cur_ofs <= req_offset;
            remain  <= clip_len;
            blocks  <= blk_cnt_w[CNT_W-1:0];
            ecnt    <= '0;
            pcnt    <= '0;
            state   <= S_ERASE;
          end
        end
        S_ERASE: state <= S_EWAIT;
        S_EWAIT: if (op_done) begin
          ecnt <= ecnt + 1'b1;
          if (op_pass) state <= S_PROG;
          else if (32'(ecnt) + 1 >= TRIES) begin
            state <= S_IDLE; done <= 1'b1; status <= ST_EFAIL;
          end else state <= S_ERASE;
        end
        S_PROG: state <= S_PWAIT;
        S_PWAIT: if (op_done) begin
          if (op_bytes == '0) begin
            pcnt <= pcnt + 1'b1;
            if (32'(pcnt) + 1 >= TRIES) begin
              state <= S_IDLE; done <= 1'b1; status <= ST_PFAIL;
            end else state <= S_ERASE;
          end else begin
            cur_ofs <= cur_ofs + AW'(op_bytes);
            remain  <= remain - W'(op_bytes);
            written <= written + W'(op_bytes);
            if (blocks == CNT_W'(1)) begin
              state <= S_IDLE; done <= 1'b1; status <= ST_OK;
            end else begin
              blocks <= blocks - 1'b1;
              ecnt   <= '0;
              pcnt   <= '0;
              state  <= S_ERASE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_wr_mgr_chk.sv
module flash_wr_mgr_chk #(
  parameter int AW     = 24,
  parameter int BLK_SH = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [1:0]      cmd_code,
  input logic            cmd_err,
  input logic            en_all,
  input logic            en_low,
  input logic            busy,
  input logic            done,
  input logic [2:0]      status,
  input logic [AW:0]     written,
  input logic            op_start,
  input logic            op_erase,
  input logic [AW-1:0]   op_addr,
  input logic [AW:0]     op_len
);
  localparam logic [AW:0] BLK = (AW+1)'(1) << BLK_SH;

  a_r1_unknown_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == 2'd3 |=> cmd_err && !en_all && !en_low);

  a_r2_prot_no_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == 3'd1 |-> written == '0);

  a_r5_erase_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    op_start && op_erase |-> op_addr[BLK_SH-1:0] == '0);

  a_r6_prog_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    op_start && !op_erase |-> op_len != '0 && op_len <= BLK - (AW+1)'(op_addr[BLK_SH-1:0]));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_op_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> busy);
endmodule

bind flash_wr_mgr flash_wr_mgr_chk #(.AW(AW), .BLK_SH(BLK_SH)) u_chk (.*);

// File: tb/flash_wr_mgr_tb.sv
module flash_wr_mgr_tb;
  localparam int CLK_P = 10;
  localparam int AW = 24;
  localparam int BS = 16;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0; logic [1:0] cmd_code = 0;
  logic cmd_err, size_sel = 0, req_valid = 0;
  logic [AW-1:0] req_offset = 0, req_len = 0;
  logic busy, done; logic [2:0] status; logic [AW:0] written;
  logic op_start, op_erase; logic [AW-1:0] op_addr; logic [AW:0] op_len;
  logic op_done = 0, op_pass = 0; logic [BS:0] op_bytes = 0;

  int checks = 0, fails = 0, cycles = 0;
  int efail_left = 0, pfail_left = 0, blk_done = 0, bad_ops = 0;
  int dly = 0; logic pend = 0, pend_erase = 0; logic [AW:0] pend_len = 0;
  bit m_all = 0, m_low = 0;

  flash_wr_mgr #(.AW(AW), .BLK_SH(BS)) u_dut (.*);

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    op_done <= 0;
    if (op_start) begin
      if (op_erase && op_addr[BS-1:0] != 0) bad_ops <= bad_ops + 1;
      if (!op_erase && (op_len == 0 || op_len > (25'd65536 - op_addr[BS-1:0]))) bad_ops <= bad_ops + 1;
      pend <= 1; pend_erase <= op_erase; pend_len <= op_len; dly <= 2;
    end else if (pend) begin
      if (dly > 0) dly <= dly - 1;
      else begin
        pend <= 0; op_done <= 1;
        if (pend_erase) begin
          op_pass <= (efail_left == 0);
          if (efail_left > 0) efail_left <= efail_left - 1;
        end else if (pfail_left > 0) begin
          op_bytes <= 0; pfail_left <= pfail_left - 1;
        end else begin
          op_bytes <= pend_len[BS:0]; blk_done <= blk_done + 1;
        end
      end
    end
  end

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [1:0] c);
    @(negedge clk); cmd_valid = 1; cmd_code = c;
    @(negedge clk); cmd_valid = 0;
    check("R1 cmd_err", cmd_err, c == 3);
    case (c)
      0, 3: begin m_all = 0; m_low = 0; end
      1: m_all = 1;
      2: m_low = 1;
    endcase
  endtask

  task automatic model(input longint ofs, input longint len, input bit sel,
                       input int ef, input int pf,
                       output int st, output longint wr, output int nb);
    longint size = sel ? 64'd4194304 : 64'd1048576;
    longint e, cnt, p, n; int ec, pc; bit ok;
    st = 0; wr = 0; nb = 0;
    if (!m_all || (ofs < 65536 && !m_low)) begin st = 1; return; end
    if (ofs >= size) begin st = (len == 0) ? 0 : 2; return; end
    if (len == 0) return;
    if (len > size - ofs) len = size - ofs;
    e = ofs + len; cnt = (e >> 16) - (ofs >> 16) + 1;
    if ((e & 65535) == 0) cnt--;
    p = ofs;
    for (longint b = 0; b < cnt; b++) begin
      ec = 0; pc = 0; ok = 0;
      while (!ok) begin
        forever begin
          ec++;
          if (ef > 0) begin ef--; if (ec >= 10) begin st = 3; return; end end
          else break;
        end
        n = 65536 - (p & 65535); if (len < n) n = len;
        if (pf > 0) begin pf--; pc++; if (pc >= 10) begin st = 4; return; end end
        else ok = 1;
      end
      p += n; len -= n; wr += n; nb++;
    end
  endtask

  task automatic run(input longint ofs, input longint len, input bit sel, input int ef, input int pf);
    int st, nb, b0; longint wr;
    model(ofs, len, sel, ef, pf, st, wr, nb);
    @(negedge clk);
    efail_left = ef; pfail_left = pf; b0 = blk_done;
    size_sel = sel; req_offset = AW'(ofs); req_len = AW'(len); req_valid = 1;
    @(negedge clk); req_valid = 0;
    while (!done && cycles < 190000) @(negedge clk);
    check("R9 status", status, st);
    check("R9 written", written, wr);
    check("R5 blocks", blk_done - b0, nb);
    check("R6 op bounds", bad_ops, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("reset busy", busy, 0);
    check("reset done", done, 0);
    check("reset cmd_err", cmd_err, 0);
    run(70000, 100, 0, 0, 0);                    // R2 general enable clear
    send_cmd(1);
    run(65535, 10, 0, 0, 0);                     // R2 low region locked
    run(65536, 10, 0, 0, 0);                     // R9 just above boot area
    send_cmd(2);
    run(0, 300, 0, 0, 0);                        // R9 low region unlocked
    run(1048576, 5, 0, 0, 0);                    // R3 range error
    run(1048576, 0, 0, 0, 0);                    // R3 zero length at end
    run(1048576, 5, 1, 0, 0);                    // R3 large device accepts
    run(5000, 0, 0, 0, 0);                       // R3 zero length inside
    run(1040000, 20000, 0, 0, 0);                // R4 clip at 1 MiB
    run(4190000, 9000, 1, 0, 0);                 // R4 clip at 4 MiB
    run(65536, 131072, 0, 0, 0);                 // R5 ends on boundary: 2 blocks
    run(65536, 131073, 0, 0, 0);                 // R5 one past: 3 blocks
    run(100000, 200000, 0, 0, 0);                // R6 unaligned multi-block
    run(200000, 70000, 0, 9, 0);                 // R7 nine failures recover
    run(200000, 70000, 0, 10, 0);                // R7 ten failures abort
    run(131072, 140000, 0, 0, 9);                // R8 nine zero results recover
    run(131072, 140000, 0, 0, 10);               // R8 abort on tenth
    run(130000, 80000, 0, 0, 0);
    send_cmd(3);                                 // R1 unknown clears both
    run(200000, 10, 0, 0, 0);
    send_cmd(1);
    run(30000, 10, 0, 0, 0);                     // R1 low enable was cleared
    send_cmd(2);
    send_cmd(0);                                 // R1 disable clears both
    run(200000, 10, 0, 0, 0);
    void'($urandom(32'd1234));
    for (int i = 0; i < 40; i++) begin
      int r = $urandom % 8;
      if (r == 0) send_cmd(0);
      if (r == 1) send_cmd(1);
      if (r == 2) send_cmd(2);
      if (r >= 3 && !m_all) send_cmd(1);
      run($urandom % 4300000, $urandom % 250000, $urandom % 2,
          ($urandom % 5 == 0) ? 11 : $urandom % 4,
          ($urandom % 5 == 0) ? 10 : $urandom % 3);
    end
    if (cycles >= 190000) check("watchdog", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule